// File: doc/BRIEF.md
# Multiplexed Host Port Slave

This block lets an external host read and write on-chip memory through a narrow 16-bit multiplexed bus. Every 32-bit memory word crosses the bus as two halfword transfers. A halfword-select line tells the block which half the host is moving. Two access-select bits pick one of four targets: a control register, an address register, a data path that keeps the address fixed, or a data path that advances the address after each word.

The host is told to stall by a wait output. That output is raised only on halfword transfers that really need an internal memory cycle, and on address-register writes. Register reads, second halfwords, and autoincrement reads that are served from a prefetched word finish with no stall. On the chip side the block uses a word-wide request/acknowledge memory port. The latency of that port may vary.

All host inputs are assumed to be already synchronous to `clk`. The access-select bits, the read/write line and the halfword-select line are captured when the address strobe falls. A transfer begins when the data strobe falls while chip select is low. The host then holds the strobe until the wait output is low, reads `hd_out` at that point, and releases the strobe.

Top module: `mhp_slave`

## Requirements
- R1: The access-select bits decode as follows: 2'b00 selects the control register, 2'b10 the address register, 2'b11 a data access with a fixed address, and 2'b01 a data access that autoincrements.
- R2: A read of the control register or the address register never raises `hwait`. The halfword-select line is ignored, so both halves return the same 16 bits. The address register reads back zero-extended to 16 bits.
- R3: Every halfword write to the address register loads `hd_in[AW-1:0]` into it whatever the halfword-select value is. It raises `hwait` for AHOLD_CYC cycles and discards any prefetched word.
- R4: A fixed-address data read raises `hwait` on the first halfword (select low) until the memory word arrives, and then returns bits 15:0. The second halfword (select high) returns bits 31:16 without a wait. The address is not changed.
- R5: In an autoincrement read sequence, only the first halfword of the first read waits. Each completed second halfword advances the address by one word and prefetches that word. The next read's halves then complete without a wait and return the next word.
- R6: A data write stores the first halfword without a wait. The second halfword writes {second, first} to memory at the current address and waits until the acknowledge arrives. In autoincrement mode the address then advances by one. Any data write discards the prefetched word.
- R7: A transfer counts only when chip select is low and the data strobe falls. Access-select, read/write and halfword-select take the values present when the address strobe fell, and later changes to those lines are ignored. `hd_oe` is high only during a qualified read.
- R8: `mem_req` stays high until `mem_ack` and drops in the cycle after `mem_ack`. There is exactly one acknowledge per request.
- R9: `hwait` shows the state of a transfer from the first clock after the strobe is sampled low. On a memory read it stays high until the word has been captured. Read data is valid once `hwait` is low.
- R10: A data access or address write that arrives while a prefetch is still outstanding is held with `hwait` high until the prefetch completes. It is then carried out with the correct result.
- R11: After reset, `hwait` and `mem_req` are low, the control and address registers read 0, and no prefetched word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hcs_n | input | 1 | Chip select, active low |
| has_n | input | 1 | Address strobe, active low; its falling edge captures the access controls |
| hstrb_n | input | 1 | Data strobe, active low |
| hsel | input | 2 | Access-select bits |
| hrd | input | 1 | 1 = read, 0 = write |
| hhi | input | 1 | Halfword select: 0 = bits 15:0, 1 = bits 31:16 |
| hd_in | input | 16 | Write data from the host |
| hd_out | output | 16 | Read data to the host |
| hd_oe | output | 1 | High while the block drives read data |
| hwait | output | 1 | High: the host must hold its strobe |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The main function is tried with these patterns: register reads on both halfword selects, fixed-address read pairs issued twice at the same address, autoincrement runs over three words, and data writes in both modes followed by read-back. Register reads with both select values show that the half line is ignored. Repeated fixed-address reads show that every first half waits while autoincrement reads stop waiting after the first word, which separates demand fetch from prefetch use. Address writes placed between autoincrement runs show that the prefetched word is discarded. Back-to-back accesses issued while a prefetch with random latency is still pending show that held transfers still return the right word.

// File: rtl/mhp_pkg.sv
package mhp_pkg;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'b00,
        SEL_DINC = 2'b01,
        SEL_ADR  = 2'b10,
        SEL_DFIX = 2'b11
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic rd;
        logic hi;
    } acc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_PREF,
        ST_AHOLD
    } st_e;

    function automatic logic is_data(sel_e s);
        return (s == SEL_DINC) || (s == SEL_DFIX);
    endfunction

    // Accesses that must wait behind an outstanding prefetch.
    function automatic logic touches_mem(acc_t a);
        return is_data(a.sel) || ((a.sel == SEL_ADR) && !a.rd);
    endfunction

endpackage

// File: rtl/mhp_capture.sv
module mhp_capture
    import mhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       as_n,
    input  logic       strb_n,
    input  logic [1:0] sel_in,
    input  logic       rd_in,
    input  logic       hi_in,
    output acc_t       acc,
    output logic       start,
    output logic       rd_drive
);
    logic as_q;
    logic strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            as_q   <= 1'b1;
            strb_q <= 1'b1;
            acc    <= '{sel: SEL_CTL, rd: 1'b0, hi: 1'b0};
        end else begin
            as_q   <= as_n;
            strb_q <= strb_n;
            if (as_q && !as_n)
                acc <= '{sel: sel_e'(sel_in), rd: rd_in, hi: hi_in};
        end
    end

    assign start    = !cs_n && !strb_n && strb_q;
    assign rd_drive = !cs_n && !strb_n && acc.rd;

endmodule

// File: rtl/mhp_engine.sv
module mhp_engine
    import mhp_pkg::*;
#(
    parameter int AW        = 10,
    parameter int AHOLD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  acc_t          acc,
    input  logic [15:0]   hd_in,
    output logic          hwait,
    output logic [15:0]   dout,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);
    localparam int CW = $clog2(AHOLD_CYC + 1);

    st_e           st;
    logic [15:0]   ctl_r;
    logic [AW-1:0] addr_r;
    logic [15:0]   wlo;
    logic [31:0]   word_r;
    logic [31:0]   pbuf;
    logic          pvld;
    logic          held_v;
    acc_t          held;
    logic [CW-1:0] cnt;
    logic [31:0]   wdat;
    logic          cur_inc;
    logic          go;
    acc_t          pick;

    always_comb begin
        pick = (st == ST_IDLE && held_v) ? held : acc;
        go   = 1'b0;
        if (st == ST_IDLE)
            go = start || held_v;
        else if (st == ST_PREF)
            go = start && !touches_mem(acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctl_r   <= '0;
            addr_r  <= '0;
            wlo     <= '0;
            word_r  <= '0;
            pbuf    <= '0;
            pvld    <= 1'b0;
            held_v  <= 1'b0;
            held    <= '{sel: SEL_CTL, rd: 1'b0, hi: 1'b0};
            cnt     <= '0;
            wdat    <= '0;
            cur_inc <= 1'b0;
            hwait   <= 1'b0;
            dout    <= '0;
        end else begin
            if (go) begin
                if (st == ST_IDLE)
                    held_v <= 1'b0;
                unique case (pick.sel)
                    SEL_CTL: begin
                        if (!pick.rd) ctl_r <= hd_in;
                        else          dout  <= ctl_r;
                        hwait <= 1'b0;
                    end
                    SEL_ADR: begin
                        if (pick.rd) begin
                            dout  <= 16'(addr_r);
                            hwait <= 1'b0;
                        end else begin
                            addr_r <= hd_in[AW-1:0];
                            pvld   <= 1'b0;
                            cnt    <= CW'(AHOLD_CYC);
                            hwait  <= 1'b1;
                            st     <= ST_AHOLD;
                        end
                    end
                    default: begin
                        cur_inc <= (pick.sel == SEL_DINC);
                        if (pick.rd && !pick.hi) begin
                            if (pick.sel == SEL_DINC && pvld) begin
                                word_r <= pbuf;
                                dout   <= pbuf[15:0];
                                pvld   <= 1'b0;
                                hwait  <= 1'b0;
                            end else begin
                                hwait <= 1'b1;
                                st    <= ST_FETCH;
                            end
                        end else if (pick.rd) begin
                            dout  <= word_r[31:16];
                            hwait <= 1'b0;
                            if (pick.sel == SEL_DINC) begin
                                addr_r <= addr_r + 1'b1;
                                st     <= ST_PREF;
                            end
                        end else if (!pick.hi) begin
                            wlo   <= hd_in;
                            hwait <= 1'b0;
                        end else begin
                            wdat  <= {hd_in, wlo};
                            pvld  <= 1'b0;
                            hwait <= 1'b1;
                            st    <= ST_STORE;
                        end
                    end
                endcase
            end

            unique case (st)
                ST_FETCH: if (mem_ack) begin
                    word_r <= mem_rdata;
                    dout   <= mem_rdata[15:0];
                    hwait  <= 1'b0;
                    st     <= ST_IDLE;
                end
                ST_STORE: if (mem_ack) begin
                    if (cur_inc) addr_r <= addr_r + 1'b1;
                    hwait <= 1'b0;
                    st    <= ST_IDLE;
                end
                ST_PREF: begin
                    if (start && touches_mem(acc)) begin
                        held_v <= 1'b1;
                        held   <= acc;
                        hwait  <= 1'b1;
                    end
                    if (mem_ack) begin
                        pbuf <= mem_rdata;
                        pvld <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                ST_AHOLD: begin
                    cnt <= cnt - 1'b1;
                    if (cnt <= CW'(1)) begin
                        hwait <= 1'b0;
                        st    <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_req   = (st == ST_FETCH) || (st == ST_STORE) || (st == ST_PREF);
    assign mem_we    = (st == ST_STORE);
    assign mem_addr  = addr_r;
    assign mem_wdata = wdat;

endmodule

// File: rtl/mhp_slave.sv
module mhp_slave
    import mhp_pkg::*;
#(
    parameter int AW        = 10,
    parameter int AHOLD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hcs_n,
    input  logic          has_n,
    input  logic          hstrb_n,
    input  logic [1:0]    hsel,
    input  logic          hrd,
    input  logic          hhi,
    input  logic [15:0]   hd_in,
    output logic [15:0]   hd_out,
    output logic          hd_oe,
    output logic          hwait,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);
    acc_t cap_acc;
    logic cap_start;

    mhp_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (hcs_n),
        .as_n     (has_n),
        .strb_n   (hstrb_n),
        .sel_in   (hsel),
        .rd_in    (hrd),
        .hi_in    (hhi),
        .acc      (cap_acc),
        .start    (cap_start),
        .rd_drive (hd_oe)
    );

    mhp_engine #(.AW(AW), .AHOLD_CYC(AHOLD_CYC)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (cap_start),
        .acc       (cap_acc),
        .hd_in     (hd_in),
        .hwait     (hwait),
        .dout      (hd_out),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/mhp_checker.sv
module mhp_checker
    import mhp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start,
    input acc_t acc,
    input logic hwait,
    input logic mem_req,
    input logic mem_ack
);
    p_regrd_nowait_r2: assert property (@(posedge clk) disable iff (rst)
        (start && acc.rd && !is_data(acc.sel)) |=> !hwait);

    p_adrwr_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !acc.rd && acc.sel == SEL_ADR) |=> hwait);

    p_hi_read_nowait_r4: assert property (@(posedge clk) disable iff (rst)
        (start && acc.rd && acc.hi && is_data(acc.sel)) |=> !hwait);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
        mem_ack |=> !mem_req);

    p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        mem_ack |-> mem_req);

endmodule

bind mhp_slave mhp_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (cap_start),
    .acc     (cap_acc),
    .hwait   (hwait),
    .mem_req (mem_req),
    .mem_ack (mem_ack)
);

// File: tb/mhp_slave_bench.sv
module mhp_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int NV         = 34;

    typedef struct packed {
        logic [1:0]  sel;
        logic        rd;
        logic        hi;
        logic [15:0] wd;
        logic        ew;
        logic [15:0] ed;
        logic        cd;
        logic [3:0]  rq;
    } vec_t;

    // sel, rd, hi, write data, expect wait, expect data, check data, requirement
    localparam vec_t TBL [NV] = '{
        '{2'b00, 1'b0, 1'b0, 16'h5A5A, 1'b0, 16'h0000, 1'b0, 4'd1},  // R1 ctl write
        '{2'b00, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h5A5A, 1'b1, 4'd2},  // R2
        '{2'b00, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h5A5A, 1'b1, 4'd2},  // R2 half ignored
        '{2'b10, 1'b0, 1'b0, 16'h0012, 1'b1, 16'h0000, 1'b0, 4'd3},  // R3
        '{2'b10, 1'b0, 1'b1, 16'h0012, 1'b1, 16'h0000, 1'b0, 4'd3},  // R3
        '{2'b10, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0012, 1'b1, 4'd2},  // R2
        '{2'b10, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0012, 1'b1, 4'd2},  // R2
        '{2'b11, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h3012, 1'b1, 4'd4},  // R4
        '{2'b11, 1'b1, 1'b1, 16'h0000, 1'b0, 16'hC012, 1'b1, 4'd4},  // R4
        '{2'b11, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h3012, 1'b1, 4'd4},  // R4 waits again
        '{2'b11, 1'b1, 1'b1, 16'h0000, 1'b0, 16'hC012, 1'b1, 4'd4},  // R4
        '{2'b10, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0012, 1'b1, 4'd4},  // R4 addr unchanged
        '{2'b01, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h3012, 1'b1, 4'd5},  // R5 first waits
        '{2'b01, 1'b1, 1'b1, 16'h0000, 1'b0, 16'hC012, 1'b1, 4'd5},  // R5
        '{2'b01, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h3013, 1'b1, 4'd5},  // R5 prefetched
        '{2'b01, 1'b1, 1'b1, 16'h0000, 1'b0, 16'hC013, 1'b1, 4'd5},  // R5
        '{2'b01, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h3014, 1'b1, 4'd5},  // R5
        '{2'b01, 1'b1, 1'b1, 16'h0000, 1'b0, 16'hC014, 1'b1, 4'd5},  // R5
        '{2'b10, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0015, 1'b1, 4'd5},  // R5 advanced
        '{2'b10, 1'b0, 1'b0, 16'h0020, 1'b1, 16'h0000, 1'b0, 4'd3},  // R3
        '{2'b01, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h3020, 1'b1, 4'd3},  // R3 prefetch dropped
        '{2'b01, 1'b1, 1'b1, 16'h0000, 1'b0, 16'hC020, 1'b1, 4'd5},  // R5
        '{2'b10, 1'b0, 1'b0, 16'h0030, 1'b1, 16'h0000, 1'b0, 4'd3},  // R3
        '{2'b01, 1'b0, 1'b0, 16'hBEEF, 1'b0, 16'h0000, 1'b0, 4'd6},  // R6
        '{2'b01, 1'b0, 1'b1, 16'h1234, 1'b1, 16'h0000, 1'b0, 4'd6},  // R6
        '{2'b10, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0031, 1'b1, 4'd6},  // R6 advanced
        '{2'b10, 1'b0, 1'b1, 16'h0030, 1'b1, 16'h0000, 1'b0, 4'd3},  // R3
        '{2'b11, 1'b1, 1'b0, 16'h0000, 1'b1, 16'hBEEF, 1'b1, 4'd6},  // R6 read back
        '{2'b11, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h1234, 1'b1, 4'd6},  // R6
        '{2'b11, 1'b0, 1'b0, 16'h5555, 1'b0, 16'h0000, 1'b0, 4'd6},  // R6
        '{2'b11, 1'b0, 1'b1, 16'h6666, 1'b1, 16'h0000, 1'b0, 4'd6},  // R6
        '{2'b11, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h5555, 1'b1, 4'd6},  // R6
        '{2'b11, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h6666, 1'b1, 4'd6},  // R6
        '{2'b10, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0030, 1'b1, 4'd6}   // R6 fixed addr
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hcs_n = 1'b1, has_n = 1'b1, hstrb_n = 1'b1;
    logic [1:0]    hsel = 2'b00;
    logic          hrd = 1'b0, hhi = 1'b0;
    logic [15:0]   hd_in = '0;
    logic [15:0]   hd_out;
    logic          hd_oe, hwait, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int req_rises = 0;
    int acks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mhp_slave #(.AW(AW), .AHOLD_CYC(2)) u_mhp_slave (
        .clk(clk), .rst(rst), .hcs_n(hcs_n), .has_n(has_n), .hstrb_n(hstrb_n),
        .hsel(hsel), .hrd(hrd), .hhi(hhi), .hd_in(hd_in), .hd_out(hd_out),
        .hd_oe(hd_oe), .hwait(hwait), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Memory model with random 1..8 cycle latency
    logic [31:0] mem [1 << AW];
    logic        busy = 1'b0;
    int          lat = 0;
    logic        req_q = 1'b0;

    initial begin
        for (int i = 0; i < (1 << AW); i++)
            mem[i] = {16'hC000 | 16'(i), 16'h3000 | 16'(i)};
        mem_ack   = 1'b0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        req_q <= mem_req;
        if (mem_req && !req_q) req_rises++;
        if (mem_ack) begin
            acks++;
            mem_ack <= 1'b0;
        end else if (!busy) begin
            if (mem_req) begin
                busy = 1'b1;
                lat  = $urandom_range(1, 8);
            end
        end else begin
            lat = lat - 1;
            if (lat == 0) begin
                busy = 1'b0;
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr] <= mem_wdata;
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_acc(input logic [1:0] s, input logic r, input logic h, input logic [15:0] wd,
                          input logic cs_on, input logic skew,
                          output logic ws, output int nw, output logic [15:0] rd, output logic oe);
        @(negedge clk);
        hsel = s; hrd = r; hhi = h; hd_in = wd; has_n = 1'b0;
        @(negedge clk);
        has_n = 1'b1;
        if (skew) begin hsel = 2'b10; hrd = 1'b0; end
        hcs_n = !cs_on; hstrb_n = 1'b0;
        @(negedge clk);
        ws = hwait; oe = hd_oe; nw = 0;
        while (hwait && nw < 400) begin
            @(negedge clk);
            nw++;
        end
        chk(!hwait, "R9 wait released", 32'(hwait), 32'h0);
        rd = hd_out;
        hstrb_n = 1'b1; hcs_n = 1'b1;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL R9 watchdog act=%0d exp<%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic        ws, oe;
        int          nw;
        logic [15:0] rd;

        idle(5);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(hwait == 1'b0, "R11 hwait", 32'(hwait), 32'h0);
        chk(mem_req == 1'b0, "R11 mem_req", 32'(mem_req), 32'h0);
        do_acc(2'b10, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'h0, "R11 addr reg", 32'(rd), 32'h0);
        do_acc(2'b00, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'h0, "R11 ctl reg", 32'(rd), 32'h0);
        chk(oe == 1'b1, "R7 oe on read", 32'(oe), 32'h1);

        for (int k = 0; k < NV; k++) begin
            idle(12);
            do_acc(TBL[k].sel, TBL[k].rd, TBL[k].hi, TBL[k].wd, 1'b1, 1'b0, ws, nw, rd, oe);
            checks++;
            if (ws !== TBL[k].ew) begin
                errors++;
                $display("FAIL R%0d wait row %0d act=%0d exp=%0d", TBL[k].rq, k, ws, TBL[k].ew);
            end
            if (TBL[k].cd) begin
                checks++;
                if (rd !== TBL[k].ed) begin
                    errors++;
                    $display("FAIL R%0d data row %0d act=%h exp=%h", TBL[k].rq, k, rd, TBL[k].ed);
                end
            end
        end

        // R7: strobe without chip select is ignored
        idle(12);
        do_acc(2'b00, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, ws, nw, rd, oe);
        do_acc(2'b00, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, ws, nw, rd, oe);
        chk(oe == 1'b0, "R7 oe without cs", 32'(oe), 32'h0);
        do_acc(2'b00, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'h5A5A, "R7 ctl unchanged", 32'(rd), 32'h5A5A);

        // R7: controls changed after address strobe are ignored
        do_acc(2'b00, 1'b1, 1'b1, 16'h0, 1'b1, 1'b1, ws, nw, rd, oe);
        chk(rd == 16'h5A5A, "R7 latched select", 32'(rd), 32'h5A5A);
        chk(ws == 1'b0, "R7 latched read no wait", 32'(ws), 32'h0);

        // R9: fixed read waits for the memory latency
        idle(12);
        do_acc(2'b10, 1'b0, 1'b0, 16'h0040, 1'b1, 1'b0, ws, nw, rd, oe);
        idle(12);
        do_acc(2'b11, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(ws == 1'b1, "R9 wait at first sample", 32'(ws), 32'h1);
        chk(nw >= 2, "R9 wait length", 32'(nw), 32'h2);
        chk(rd == 16'h3040, "R9 data at release", 32'(rd), 32'h3040);

        // R10: back-to-back autoincrement reads while prefetch is pending
        do_acc(2'b01, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        do_acc(2'b01, 1'b1, 1'b1, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'hC040, "R10 hi word 40", 32'(rd), 32'hC040);
        do_acc(2'b01, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'h3041, "R10 lo word 41 held", 32'(rd), 32'h3041);
        do_acc(2'b01, 1'b1, 1'b1, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'hC041, "R10 hi word 41", 32'(rd), 32'hC041);
        // address write arriving during the prefetch of word 42
        do_acc(2'b10, 1'b0, 1'b0, 16'h0050, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(ws == 1'b1, "R10 held addr write waits", 32'(ws), 32'h1);
        do_acc(2'b01, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'h3050, "R10 fresh fetch after held write", 32'(rd), 32'h3050);
        chk(ws == 1'b1, "R10 fetch waits", 32'(ws), 32'h1);
        do_acc(2'b01, 1'b1, 1'b1, 16'h0, 1'b1, 1'b0, ws, nw, rd, oe);
        chk(rd == 16'hC050, "R10 hi word 50", 32'(rd), 32'hC050);

        // R8: one acknowledge per request, request idle afterwards
        idle(20);
        chk(mem_req == 1'b0, "R8 req idle", 32'(mem_req), 32'h0);
        chk(req_rises == acks && acks > 0, "R8 req/ack count", 32'(acks), 32'(req_rises));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule